// File: doc/BRIEF.md
# SDRAM Read Burst Output Pipeline

This block models the data output side of a synchronous DRAM while it serves READ bursts. A decoded READ command arrives with its starting column, the programmed burst length and a CAS latency of 2 or 3 cycles. From that point a burst sequencer steps through the columns of the burst, one per cycle, and fetches a word for each from a column-indexed array. A latency pipeline then holds each word until the edge on which it must appear. The data bus is modelled as a data value plus an output-enable flag. The enable is low whenever the pins would float.

A per-cycle DQM input blanks the bus two cycles after it is sampled, without stalling the burst. A READ that arrives while a burst is running cuts that burst short. The words of the new READ follow the old ones without a gap. When the last word has been shown, the bus returns to high impedance by itself. The surrounding command decoder must keep `cl3_i` constant while any word is in flight.

Top module: `sdram_rd_pipe`

## Requirements
- R1: While `rst_ni` is low, `dq_oe_o` is 0 and `dq_o` is 0, and both take these values as soon as reset is asserted.
- R2: The word shown for column c is the low 16 bits of (c × 40503) XOR 0x5A3C.
- R3: With `cl3_i` = 0, the first word of a READ sampled on edge T is shown with `dq_oe_o` = 1 after edge T+2.
- R4: With `cl3_i` = 1, the first word of a READ sampled on edge T is shown after edge T+3.
- R5: Each later word of a burst is shown on the edge that follows the previous word, with no idle cycle between them.
- R6: `bl_i` is captured with the READ and selects the burst length: 0 gives 1 word, 1 gives 2, 2 gives 4 and 3 gives 8. Exactly that many words are shown.
- R7: For a burst of length L that starts at column c, word k comes from column (c AND NOT (L−1)) OR ((c + k) AND (L−1)). The order therefore wraps inside the aligned block of L columns.
- R8: If `dqm_i` is 1 on edge T, then after edge T+2 `dq_oe_o` is 0 and `dq_o` is 0 for that one cycle. The burst still advances, so the masked word is lost.
- R9: A READ sampled while a burst is running ends that burst. The old burst's words stop after edge T+CL−1, and the new burst's first word appears after edge T+CL with no gap.
- R10: `dq_oe_o` is 0 in every cycle for which no burst word is scheduled. `dq_o` is 0 whenever `dq_oe_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_i | input | 1 | Decoded READ command, sampled on the clock edge |
| rd_col_i | input | COL_W | Starting column of the READ |
| cl3_i | input | 1 | CAS latency select: 0 gives 2 cycles, 1 gives 3 cycles |
| bl_i | input | 2 | Burst length code, captured with the READ |
| dqm_i | input | 1 | Output mask; blanks the bus two cycles later |
| dq_o | output | DATA_W | Data value on the bus; 0 while not driven |
| dq_oe_o | output | 1 | Output enable; 0 means high impedance |

## Verification
The bench tracks the expected bus state one cycle at a time. It targets starting columns near the end of an aligned block, where an implementation that carries into the upper column bits instead of wrapping would show words from the next block. It issues READs in the middle of a burst and READs on back-to-back cycles at both latencies. A design that let the old burst continue would show the wrong words, and one that restarted the pipeline would leave an idle cycle on the bus. DQM pulses land in the middle of bursts. A lag of one or three cycles would blank the wrong word, and a design that stalled instead of dropping the word would shift every later word by one cycle. Latency 3 is exercised alongside latency 2 to show that the latency select chooses the right pipeline stage.

// File: rtl/sdram_rd_pkg.sv
package sdram_rd_pkg;

  // number of words for a burst length code
  function automatic logic [3:0] bl_words(logic [1:0] code);
    return 4'd1 << code;
  endfunction

  // computed array content, indexed by column
  function automatic logic [31:0] col_word(logic [31:0] col);
    return (col * 32'd40503) ^ 32'h0000_5A3C;
  endfunction

endpackage

// File: rtl/rd_burst_seq.sv
module rd_burst_seq
  import sdram_rd_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [COL_W-1:0] col_i,
  input  logic [1:0]       bl_i,
  output logic             v_o,
  output logic [COL_W-1:0] col_o
);

  localparam int CNT_W = 3;

  logic             v_q;
  logic [CNT_W-1:0] left_q;
  logic [COL_W-1:0] col_q, mask_q, mask_d;

  assign mask_d = COL_W'(bl_words(bl_i) - 4'd1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_q    <= 1'b0;
      left_q <= '0;
      col_q  <= '0;
      mask_q <= '0;
    end else if (load_i) begin
      // a new READ always restarts the sequence (truncation)
      v_q    <= 1'b1;
      left_q <= CNT_W'(bl_words(bl_i) - 4'd1);
      col_q  <= col_i;
      mask_q <= mask_d;
    end else if (v_q) begin
      if (left_q == '0) begin
        v_q <= 1'b0;
      end else begin
        left_q <= left_q - 1'b1;
        col_q  <= (col_q & ~mask_q) | ((col_q + COL_W'(1)) & mask_q);
      end
    end
  end

  assign v_o   = v_q;
  assign col_o = col_q;

  AST_WRAP_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    v_q && !load_i |=> !v_q || ((col_q & ~mask_q) == ($past(col_q) & ~$past(mask_q)))); // R7
  AST_NO_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    v_q && left_q != '0 |=> v_q); // R5
  AST_BL_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && bl_i == 2'd0 ##1 !load_i |=> !v_q); // R6

endmodule

// File: rtl/rd_delay_line.sv
module rd_delay_line #(
  parameter int W     = 17,
  parameter int DEPTH = 2,
  localparam int SEL_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [W-1:0]     d_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic [W-1:0]     q_o
);

  logic [DEPTH-1:0][W-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q <= '0;
    else         stg_q <= {stg_q[DEPTH-2:0], d_i};
  end

  // stage i holds what d_i carried i+1 edges ago
  assign q_o = stg_q[sel_i];

endmodule

// File: rtl/sdram_rd_pipe.sv
module sdram_rd_pipe
  import sdram_rd_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int COL_W  = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_i,
  input  logic [COL_W-1:0]  rd_col_i,
  input  logic              cl3_i,
  input  logic [1:0]        bl_i,
  input  logic              dqm_i,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe_o
);

  localparam int MAX_CL     = 3;
  localparam int PIPE_D     = MAX_CL - 1;
  localparam int PIPE_SEL_W = $clog2(PIPE_D);
  localparam int DQM_LAG    = 2;
  localparam int DQM_SEL_W  = $clog2(DQM_LAG);
  localparam int SLOT_W     = DATA_W + 1;

  logic              seq_v;
  logic [COL_W-1:0]  seq_col;
  logic [DATA_W-1:0] seq_word;
  logic [SLOT_W-1:0] slot_d, slot_tap;
  logic              dqm_tap;
  logic              drive_d;

  rd_burst_seq #(.COL_W(COL_W)) i_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (rd_i),
    .col_i  (rd_col_i),
    .bl_i   (bl_i),
    .v_o    (seq_v),
    .col_o  (seq_col)
  );

  assign seq_word = DATA_W'(col_word(32'(seq_col)));
  assign slot_d   = {seq_v, seq_v ? seq_word : '0};

  // CL-1 stages, then the output register
  rd_delay_line #(.W(SLOT_W), .DEPTH(PIPE_D)) i_lat (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (slot_d),
    .sel_i  (PIPE_SEL_W'(cl3_i)),
    .q_o    (slot_tap)
  );

  rd_delay_line #(.W(1), .DEPTH(DQM_LAG)) i_dqm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (dqm_i),
    .sel_i  (DQM_SEL_W'(DQM_LAG - 1)),
    .q_o    (dqm_tap)
  );

  assign drive_d = slot_tap[DATA_W] & ~dqm_tap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dq_oe_o <= 1'b0;
      dq_o    <= '0;
    end else begin
      dq_oe_o <= drive_d;
      dq_o    <= drive_d ? slot_tap[DATA_W-1:0] : '0;
    end
  end

  always @(posedge clk_i) begin
    if (!rst_ni) AST_RST_IDLE: assert (!dq_oe_o && dq_o == '0); // R1
  end
  AST_DQM_HIZ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dqm_tap |=> !dq_oe_o); // R8
  AST_QUIET_BUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dq_oe_o |-> dq_o == '0); // R10

endmodule

// File: tb/test_sdram_rd_pipe.sv
`timescale 1ns/1ps
module test_sdram_rd_pipe;

  localparam int DATA_W = 16;
  localparam int COL_W  = 9;
  localparam int NSLOT  = 4096;
  localparam int NVEC   = 8;
  // {cl3, bl code, column}
  localparam logic [11:0] VEC [NVEC] = '{
    {1'b0, 2'd2, 9'h000}, {1'b1, 2'd2, 9'h005}, {1'b0, 2'd0, 9'h0FF},
    {1'b1, 2'd1, 9'h003}, {1'b0, 2'd3, 9'h1FE}, {1'b1, 2'd3, 9'h040},
    {1'b0, 2'd1, 9'h1FF}, {1'b1, 2'd0, 9'h123}
  };

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              rd_i = 1'b0;
  logic [COL_W-1:0]  rd_col_i = '0;
  logic              cl3_i = 1'b0;
  logic [1:0]        bl_i = '0;
  logic              dqm_i = 1'b0;
  logic [DATA_W-1:0] dq_o;
  logic              dq_oe_o;

  int    cyc = 0;
  int    n_chk = 0;
  int    n_err = 0;
  bit    chk_en = 1'b0;
  bit    exp_oe [NSLOT];
  bit    msk    [NSLOT];
  logic [DATA_W-1:0] exp_dq [NSLOT];
  string exp_tag [NSLOT];

  sdram_rd_pipe #(.DATA_W(DATA_W), .COL_W(COL_W)) i_sdram_rd_pipe (
    .clk_i, .rst_ni, .rd_i, .rd_col_i, .cl3_i, .bl_i, .dqm_i, .dq_o, .dq_oe_o
  );

  always #2 clk_i = ~clk_i;
  always @(posedge clk_i) cyc++;

  function automatic logic [DATA_W-1:0] model_word(int c);
    logic [31:0] t;
    t = c * 40503;
    return t[DATA_W-1:0] ^ 16'h5A3C;
  endfunction

  task automatic clear_model();
    for (int i = 0; i < NSLOT; i++) begin
      exp_oe[i] = 1'b0; msk[i] = 1'b0; exp_dq[i] = '0; exp_tag[i] = "";
    end
  endtask

  // READ sampled on edge e
  task automatic sched(int e, bit c3, logic [1:0] bl, int col, bit trunc);
    int first, len, c;
    first = e + (c3 ? 3 : 2);
    len   = 1 << bl;
    for (int i = first; i < first + 8; i++) exp_oe[i] = 1'b0;
    for (int k = 0; k < len; k++) begin
      c = (col & ~(len - 1)) | ((col + k) & (len - 1));
      exp_oe[first+k] = 1'b1;
      exp_dq[first+k] = model_word(c);
      if (k == 0)                  exp_tag[first+k] = c3 ? "R4/R2" : "R3/R2";
      else if (c < col)            exp_tag[first+k] = "R7/R2";
      else                         exp_tag[first+k] = "R5/R6";
      if (k == 0 && trunc)         exp_tag[first+k] = "R9";
    end
  endtask

  task automatic rd(bit c3, logic [1:0] bl, int col, bit trunc);
    @(negedge clk_i);
    rd_i = 1'b1; cl3_i = c3; bl_i = bl; rd_col_i = COL_W'(col);
    sched(cyc + 1, c3, bl, col, trunc);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      rd_i = 1'b0;
    end
  endtask

  task automatic pulse_dqm();
    @(negedge clk_i);
    rd_i = 1'b0; dqm_i = 1'b1;
    msk[cyc + 3] = 1'b1;
    @(negedge clk_i);
    dqm_i = 1'b0;
  endtask

  task automatic check_quiet(string tag);
    n_chk++;
    if (dq_oe_o !== 1'b0 || dq_o !== '0) begin
      n_err++;
      $display("FAIL %s: oe=%b dq=%h expected oe=0 dq=0000", tag, dq_oe_o, dq_o);
    end
  endtask

  task automatic finish_up();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  // per-cycle comparison against the model
  always @(negedge clk_i) begin
    if (chk_en && cyc < NSLOT) begin
      bit e_oe;
      logic [DATA_W-1:0] e_dq;
      string tag;
      e_oe = exp_oe[cyc] && !msk[cyc];
      e_dq = e_oe ? exp_dq[cyc] : '0;
      tag  = msk[cyc] ? "R8" : (exp_oe[cyc] ? exp_tag[cyc] : "R10/R6");
      n_chk++;
      if (dq_oe_o !== e_oe || dq_o !== e_dq) begin
        n_err++;
        $display("FAIL %s cycle %0d: oe=%b dq=%h expected oe=%b dq=%h",
                 tag, cyc, dq_oe_o, dq_o, e_oe, e_dq);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    n_err++;
    $display("FAIL watchdog: run did not complete");
    finish_up();
  end

  initial begin
    clear_model();
    repeat (3) @(negedge clk_i);
    check_quiet("R1");
    rst_ni = 1'b1;
    chk_en = 1'b1;
    idle(2);

    // table walk: latency, length, order
    for (int v = 0; v < NVEC; v++) begin
      rd(VEC[v][11], VEC[v][10:9], int'(VEC[v][8:0]), 1'b0);
      idle(14);
    end

    // R8: DQM in mid burst, two-cycle lag, burst not stalled
    rd(1'b0, 2'd3, 'h010, 1'b0);
    idle(2);
    pulse_dqm();
    idle(12);
    rd(1'b1, 2'd2, 'h0A2, 1'b0);
    pulse_dqm();
    idle(12);

    // R9: truncation at both latencies
    rd(1'b0, 2'd3, 'h020, 1'b0);
    idle(3);
    rd(1'b0, 2'd2, 'h083, 1'b1);
    idle(12);
    rd(1'b1, 2'd3, 'h0C4, 1'b0);
    idle(2);
    rd(1'b1, 2'd1, 'h011, 1'b1);
    idle(12);

    // R5/R9: back-to-back READs keep the bus continuous
    rd(1'b1, 2'd1, 'h030, 1'b0);
    rd(1'b1, 2'd1, 'h032, 1'b1);
    rd(1'b1, 2'd0, 'h1F0, 1'b1);
    idle(12);
    rd(1'b0, 2'd0, 'h100, 1'b0);
    rd(1'b0, 2'd0, 'h101, 1'b1);
    rd(1'b0, 2'd0, 'h102, 1'b1);
    idle(12);

    // R1: reset in the middle of a burst
    rd(1'b0, 2'd3, 'h000, 1'b0);
    idle(4);
    @(negedge clk_i);
    chk_en = 1'b0;
    rst_ni = 1'b0;
    #0.5;
    check_quiet("R1");
    clear_model();
    @(negedge clk_i);
    check_quiet("R1");
    rst_ni = 1'b1;
    chk_en = 1'b1;
    idle(10);

    chk_en = 1'b0;
    finish_up();
  end

endmodule